// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps track of line reservations taken by load-linked operations and decides whether each later store-conditional succeeds. Completion events arrive with a byte address, a context identifier, an operation kind and a flag telling whether the line is resident in the cache. The coherence side reports separately when a line loses its permission. For every operation, one cycle later, the block returns a one-bit status value for the core and a write enable for the data path. A failed store-conditional gets status 0 and no write.

The monitor holds a small, parameterised set of reservation entries. Each entry has a valid bit, a line tag and a context identifier. A load-linked refreshes its own entry if one already exists. Otherwise it fills a free entry, or replaces the oldest entry when the set is full. Store-conditionals and ordinary writes from the owning context remove the matching reservation. An invalidation removes every reservation on its line, for all contexts.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation is held and `resp_valid` is 0. A store-conditional issued first therefore fails.
- R2: A load-linked (`op_kind`=2'b01) returns status 1 with no write enable and reserves its line for its context. A following store-conditional (`op_kind`=2'b10) from that context to that line returns status 1 and write enable 1.
- R3: Every store-conditional removes the reservation on its line for its context, whether it succeeds or fails, so a second store-conditional fails.
- R4: A store-conditional with no reservation for its own context on its line returns status 0 and write enable 0, even if another context holds the line.
- R5: An ordinary write (`op_kind`=2'b11) always returns status 1 and write enable 1. It removes the same context's reservation on its line.
- R6: An ordinary write from a different context leaves the reservation in place.
- R7: An invalidation (`inv_valid`) removes all reservations on its line for every context. It leaves other lines untouched.
- R8: When an invalidation and a store-conditional to the same line arrive in the same cycle, the invalidation is applied first and the store-conditional fails.
- R9: If `op_line_present` is 0, the operation returns status 1 and reservations are not changed. A store-conditional in that case also asserts write enable.
- R10: Matching is done per line. Address bits below `LINE_OFF` are ignored, and addresses in different lines never match.
- R11: A load-linked on a full monitor replaces the entry filled or refreshed longest ago. A load-linked that refreshes an existing reservation makes it the newest.
- R12: The response appears exactly one cycle after `op_valid`. An "other" operation (`op_kind`=2'b00) returns status 1 and write enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Completion event present |
| op_kind | input | 2 | 00 other, 01 load-linked, 10 store-conditional, 11 write |
| op_addr | input | ADDR_W | Byte address of the access |
| op_ctx | input | CTX_W | Issuing context identifier |
| op_line_present | input | 1 | Line resident in the cache |
| inv_valid | input | 1 | Permission lost for a line |
| inv_addr | input | ADDR_W | Address of the line losing permission |
| resp_valid | output | 1 | Response for the previous cycle's operation |
| resp_status | output | 1 | Status value returned to the core (1 success) |
| resp_wr_en | output | 1 | Data write enable for the operation |

## Verification
The assertions check the per-cycle rules on every cycle:
- the one-cycle response latency;
- status 1 for load-linked, write, absent-line and other operations;
- the link between a failed status and a suppressed write;
- the failure of a store-conditional that collides with an invalidation of its line.

Whether a store-conditional should succeed depends on the history of reservations, so only the bench scenarios can show it. These scenarios cover removal by store-conditional, write and invalidation, context separation, line granularity, and oldest-entry replacement with refresh.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int CTX_W    = 2,
  parameter int ENTRIES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [CTX_W-1:0]  op_ctx,
  input  logic              op_line_present,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              resp_valid,
  output logic              resp_status,
  output logic              resp_wr_en
);
  localparam int TAG_W = ADDR_W - LINE_OFF;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] ent_v;
  logic [TAG_W-1:0]   ent_tag [ENTRIES];
  logic [CTX_W-1:0]   ent_ctx [ENTRIES];
  logic [ENTRIES-1:0] older   [ENTRIES];

  logic [TAG_W-1:0] op_tag, inv_tag;
  assign op_tag  = op_addr[ADDR_W-1:LINE_OFF];
  assign inv_tag = inv_addr[ADDR_W-1:LINE_OFF];
  logic unused_offset_bits;
  assign unused_offset_bits = ^{op_addr[LINE_OFF-1:0], inv_addr[LINE_OFF-1:0]};

  logic is_ll, is_sc, is_wr, act;
  assign is_ll = op_kind == 2'b01;
  assign is_sc = op_kind == 2'b10;
  assign is_wr = op_kind == 2'b11;
  assign act   = op_valid && op_line_present;

  logic [ENTRIES-1:0] inv_hit, live, own_hit, clr, is_oldest;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign inv_hit[i] = inv_valid && ent_v[i] && (ent_tag[i] == inv_tag);
    assign live[i]    = ent_v[i] && !inv_hit[i];
    assign own_hit[i] = live[i] && (ent_tag[i] == op_tag) && (ent_ctx[i] == op_ctx);
    assign clr[i]     = act && (is_sc || is_wr) && own_hit[i];
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      is_oldest[i] = live[i];
      for (int j = 0; j < ENTRIES; j++)
        if (j != i && live[j] && older[j][i]) is_oldest[i] = 1'b0;
    end
  end

  logic [IDX_W-1:0] own_idx, free_idx, old_idx, slot;
  logic any_own, any_free;
  always_comb begin
    own_idx = '0; free_idx = '0; old_idx = '0;
    any_own = 1'b0; any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (own_hit[i])   begin own_idx  = IDX_W'(i); any_own  = 1'b1; end
      if (!live[i])     begin free_idx = IDX_W'(i); any_free = 1'b1; end
      if (is_oldest[i]) old_idx = IDX_W'(i);
    end
    slot = any_own ? own_idx : (any_free ? free_idx : old_idx);
  end

  logic alloc, sc_ok;
  assign alloc = act && is_ll;
  assign sc_ok = !op_line_present || any_own;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_tag[i] <= '0;
        ent_ctx[i] <= '0;
        older[i]   <= '0;
      end
    end else begin
      ent_v <= live & ~clr;
      if (alloc) begin
        ent_v[slot]   <= 1'b1;
        ent_tag[slot] <= op_tag;
        ent_ctx[slot] <= op_ctx;
        for (int j = 0; j < ENTRIES; j++) begin
          older[j][slot] <= (IDX_W'(j) != slot);
          older[slot][j] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_status <= 1'b0;
      resp_wr_en  <= 1'b0;
    end else begin
      resp_valid  <= op_valid;
      resp_status <= op_valid && (is_sc ? sc_ok : 1'b1);
      resp_wr_en  <= op_valid && (is_wr || (is_sc && sc_ok));
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [1:0]        op_kind,
  input logic [ADDR_W-1:0] op_addr,
  input logic              op_line_present,
  input logic              inv_valid,
  input logic [ADDR_W-1:0] inv_addr,
  input logic              resp_valid,
  input logic              resp_status,
  input logic              resp_wr_en
);
  logic same_line;
  assign same_line = op_addr[ADDR_W-1:LINE_OFF] == inv_addr[ADDR_W-1:LINE_OFF];

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> resp_valid); // R12
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !resp_valid); // R12
  AST_OTHER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == 2'b00 |=> resp_status && !resp_wr_en); // R12
  AST_LL_SUCCEEDS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == 2'b01 |=> resp_status && !resp_wr_en); // R2
  AST_WRITE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == 2'b11 |=> resp_status && resp_wr_en); // R5
  AST_FAIL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_status |-> !resp_wr_en); // R4
  AST_ABSENT_SUCCEEDS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_line_present |=> resp_status); // R9
  AST_INV_BEATS_SC: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == 2'b10 && op_line_present && inv_valid && same_line
      |=> !resp_status && !resp_wr_en); // R8
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF)) u_chk (.*);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
  localparam int ADDR_W = 32, LINE_OFF = 6, CTX_W = 2, ENTRIES = 4;
  localparam logic [1:0] K_OTH = 2'b00, K_LL = 2'b01, K_SC = 2'b10, K_WR = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, op_line_present = 1'b0, inv_valid = 1'b0;
  logic [1:0] op_kind = '0;
  logic [ADDR_W-1:0] op_addr = '0, inv_addr = '0;
  logic [CTX_W-1:0] op_ctx = '0;
  logic resp_valid, resp_status, resp_wr_en;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  llsc_monitor #(.ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .CTX_W(CTX_W), .ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
    .op_ctx(op_ctx), .op_line_present(op_line_present), .inv_valid(inv_valid),
    .inv_addr(inv_addr), .resp_valid(resp_valid), .resp_status(resp_status),
    .resp_wr_en(resp_wr_en));

  function automatic logic [ADDR_W-1:0] ln(int n);
    return ADDR_W'(n) << LINE_OFF;
  endfunction

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s valid/status/wr actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic op(string req, logic [1:0] k, logic [ADDR_W-1:0] a, int c, logic pres,
                    logic iv, logic [ADDR_W-1:0] ia, logic es, logic ew);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_addr = a; op_ctx = CTX_W'(c); op_line_present = pres;
    inv_valid = iv; inv_addr = ia;
    @(negedge clk);
    op_valid = 1'b0; inv_valid = 1'b0;
    chk(req, {resp_valid, resp_status, resp_wr_en}, {1'b1, es, ew});
  endtask

  task automatic inv(logic [ADDR_W-1:0] a);
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = a;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset", {resp_valid, resp_status, resp_wr_en}, 3'b000);
    op("R1 sc after reset", K_SC, ln(1), 0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_basic();
    op("R2 ll", K_LL, ln(2), 0, 1, 0, 0, 1, 0);
    op("R2 sc ok", K_SC, ln(2), 0, 1, 0, 0, 1, 1);
    op("R3 second sc", K_SC, ln(2), 0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_ctx();
    op("R4 ll ctx1", K_LL, ln(3), 1, 1, 0, 0, 1, 0);
    op("R4 sc ctx0", K_SC, ln(3), 0, 1, 0, 0, 0, 0);
    op("R4 sc ctx1", K_SC, ln(3), 1, 1, 0, 0, 1, 1);
  endtask

  task automatic t_write();
    op("R5 ll", K_LL, ln(4), 0, 1, 0, 0, 1, 0);
    op("R5 write", K_WR, ln(4), 0, 1, 0, 0, 1, 1);
    op("R5 sc after write", K_SC, ln(4), 0, 1, 0, 0, 0, 0);
    op("R6 ll", K_LL, ln(5), 0, 1, 0, 0, 1, 0);
    op("R6 write other ctx", K_WR, ln(5), 2, 1, 0, 0, 1, 1);
    op("R6 sc survives", K_SC, ln(5), 0, 1, 0, 0, 1, 1);
  endtask

  task automatic t_inv();
    op("R7 ll ctx0", K_LL, ln(6), 0, 1, 0, 0, 1, 0);
    op("R7 ll ctx1", K_LL, ln(6), 1, 1, 0, 0, 1, 0);
    inv(ln(7));
    op("R7 other line inv", K_SC, ln(6), 0, 1, 0, 0, 1, 1);
    op("R7 ll ctx0 again", K_LL, ln(6), 0, 1, 0, 0, 1, 0);
    inv(ln(6) + 32'h10);
    op("R7 sc ctx0 after inv", K_SC, ln(6), 0, 1, 0, 0, 0, 0);
    op("R7 sc ctx1 after inv", K_SC, ln(6), 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_race();
    op("R8 ll", K_LL, ln(8), 0, 1, 0, 0, 1, 0);
    op("R8 sc with inv", K_SC, ln(8), 0, 1, 1, ln(8), 0, 0);
    op("R8 ll again", K_LL, ln(8), 0, 1, 0, 0, 1, 0);
    op("R8 sc with other inv", K_SC, ln(8), 0, 1, 1, ln(9), 1, 1);
  endtask

  task automatic t_absent();
    op("R9 ll absent", K_LL, ln(10), 0, 0, 0, 0, 1, 0);
    op("R9 sc no lock taken", K_SC, ln(10), 0, 1, 0, 0, 0, 0);
    op("R9 sc absent", K_SC, ln(10), 0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_line();
    op("R10 ll offset", K_LL, ln(11) + 32'h04, 0, 1, 0, 0, 1, 0);
    op("R10 sc next line", K_SC, ln(12), 0, 1, 0, 0, 0, 0);
    op("R10 sc same line", K_SC, ln(11) + 32'h3C, 0, 1, 0, 0, 1, 1);
  endtask

  task automatic t_replace();
    for (int i = 0; i < 5; i++) op("R11 fill", K_LL, ln(20 + i), 0, 1, 0, 0, 1, 0);
    op("R11 oldest evicted", K_SC, ln(20), 0, 1, 0, 0, 0, 0);
    for (int i = 1; i < 5; i++) op("R11 kept", K_SC, ln(20 + i), 0, 1, 0, 0, 1, 1);
    for (int i = 0; i < 4; i++) op("R11 fill2", K_LL, ln(30 + i), 0, 1, 0, 0, 1, 0);
    op("R11 refresh", K_LL, ln(30), 0, 1, 0, 0, 1, 0);
    op("R11 new", K_LL, ln(34), 0, 1, 0, 0, 1, 0);
    op("R11 second evicted", K_SC, ln(31), 0, 1, 0, 0, 0, 0);
    op("R11 refreshed kept", K_SC, ln(30), 0, 1, 0, 0, 1, 1);
  endtask

  task automatic t_other();
    op("R12 other op", K_OTH, ln(40), 0, 1, 0, 0, 1, 0);
    @(negedge clk);
    chk("R12 idle", {resp_valid, resp_status, resp_wr_en}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset state", {resp_valid, resp_status, resp_wr_en}, 3'b000);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_ctx();
    t_write();
    t_inv();
    t_race();
    t_absent();
    t_line();
    t_replace();
    t_other();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 in reset", {resp_valid, resp_status, resp_wr_en}, 3'b000);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule